// File: doc/BRIEF.md
# PWM and Pulse-Capture Timer Channel

This block is a single timer channel with two operating modes, picked by a mode input that is latched whenever the channel is idle. In output mode it drives a repeating pulse train. The train is set by a pulse width and a period, both counted in clock cycles. Software writes the pair into holding registers. The counter moves a new pair into its working registers only at the boundary between two periods, so a period never mixes an old width with a new period.

In capture mode the channel measures an incoming pulse train. The width is the number of cycles from a rising edge to the following falling edge. The period is the number of cycles from one rising edge to the next. Both results become visible on the same clock edge, at the rising edge that closes the period. While capture mode is selected, software writes to the width and period registers are discarded.

Each time the output channel is started, it checks the held pair and refuses to run a pair that makes no sense. It reports the reason as a two-bit code and raises an error flag. In capture mode, a counter that runs out of range raises the same flag with its own code. Every completed period produces a one-cycle interrupt pulse.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset, pin_out, irq and err_flag are 0, err_code is 0, and rd_width and rd_period read 0.
- R2: In output mode, when enable is first sampled high with a plausible pair (W, P), pin_out is 1 for the first W cycles of each P-cycle period and 0 for the rest. The first period starts in the cycle after that sampling edge.
- R3: irq is high for exactly one cycle after each completed period. In output mode this is the first cycle of the next period. In capture mode it is the cycle after the closing rising edge.
- R4: At an output-mode start, a period of 0 or 1 leaves the channel stopped, sets err_flag and sets err_code to 1. This code takes priority over the width code. A later successful start clears err_flag and err_code to 0.
- R5: At an output-mode start with a plausible period, a width of 0 or a width not below the period leaves the channel stopped, sets err_flag and sets err_code to 2.
- R6: Writes through wr_width and wr_period go to the holding registers and show at once on rd_width and rd_period. The running waveform changes only at the next period boundary, and it takes both values of the pair together.
- R7: At a period boundary, a held pair that would fail the start check is not loaded. The previous width and period keep running.
- R8: In capture mode, with the first qualifying rising edge seen at edge e0, a falling edge seen at e0+H and the next rising edge seen at e0+P, rd_width becomes H and rd_period becomes P on that same edge.
- R9: While capture mode is selected, writes through wr_width and wr_period leave rd_width and rd_period unchanged.
- R10: In capture mode, if a period reaches 2^CNT_W-1 cycles without a new rising edge, err_flag is set and err_code becomes 3.
- R11: After enable is sampled low, pin_out is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cap | input | 1 | Mode select, latched while idle: 0 output, 1 capture |
| enable | input | 1 | Run request; a rising level starts the channel |
| wr_width | input | 1 | Write strobe for the width holding register |
| wr_period | input | 1 | Write strobe for the period holding register |
| wr_data | input | CNT_W | Write data for both strobes |
| rd_width | output | CNT_W | Held width (output mode) or captured width (capture mode) |
| rd_period | output | CNT_W | Held period (output mode) or captured period (capture mode) |
| pin_in | input | 1 | Pulse train to measure, synchronous to clk |
| pin_out | output | 1 | Generated pulse train |
| irq | output | 1 | One-cycle pulse per completed period |
| err_flag | output | 1 | Configuration or overflow error |
| err_code | output | 2 | 0 none, 1 bad period, 2 bad width, 3 capture overflow |

## Verification
The bench sweeps every legal pair with periods from 2 to 6 across two periods. A design with an off-by-one in its compare or its wrap point would stretch or shorten the high phase, or move the interrupt by a cycle. It writes a new pair in the middle of a period, which catches a design that applies the width at once instead of at the boundary. It also writes an implausible period while running, which catches a design that stalls or glitches by loading it. Capture is swept over high and low times from 1 to 4 cycles, where a counter that starts at the wrong value reports widths one off. The bench also checks discarded writes in capture mode, every error-code priority case, and a rising edge that never returns, where a design without overflow handling would wrap silently.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_PERIOD = 2'd1,
        ERR_WIDTH  = 2'd2,
        ERR_OVF    = 2'd3
    } tmr_err_e;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_CAP = 1'b1
    } tmr_mode_e;

endpackage

// File: rtl/tmr_plaus.sv
module tmr_plaus #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] width_i,
    input  logic [CNT_W-1:0] period_i,
    output tmr_pkg::tmr_err_e code_o
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);

    always_comb begin
        if (period_i < MIN_PERIOD) begin
            code_o = ERR_PERIOD;
        end else if (width_i == '0 || width_i >= period_i) begin
            code_o = ERR_WIDTH;
        end else begin
            code_o = ERR_NONE;
        end
    end

    always_comb begin
        assert (code_o != ERR_NONE || (period_i > width_i && width_i != '0))
            else $error("AST_PLAUS_RESULT"); // R5
    end

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             pin_i,
    output logic             cap_stb_o,
    output logic [CNT_W-1:0] cap_width_o,
    output logic [CNT_W-1:0] cap_period_o,
    output logic             ovf_stb_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wtmp;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       rise, fall;

    assign rise = pin_i & ~st_q.prev;
    assign fall = ~pin_i & st_q.prev;

    assign cap_stb_o    = active_i && st_q.armed && rise;
    assign ovf_stb_o    = active_i && st_q.armed && !rise && st_q.cnt == CNT_MAX;
    assign cap_width_o  = st_q.wtmp;
    assign cap_period_o = st_q.cnt;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        if (!active_i) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (rise) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_ONE;
        end else if (st_q.armed) begin
            if (fall) begin
                st_d.wtmp = st_q.cnt;
            end
            if (st_q.cnt == CNT_MAX) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_o |-> (cap_width_o < cap_period_o && cap_width_o != '0)) // R8
        else $error("AST_CAP_ORDER");

endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cap,
    input  logic             enable,
    input  logic             wr_width,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_width,
    output logic [CNT_W-1:0] rd_period,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             irq,
    output logic             err_flag,
    output logic [1:0]       err_code
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        tmr_mode_e        mode;
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act_w;
        logic [CNT_W-1:0] act_p;
        logic [CNT_W-1:0] reg_w;
        logic [CNT_W-1:0] reg_p;
        logic             irq;
        logic             err;
        tmr_err_e         code;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    tmr_err_e         chk_code;
    logic             cap_active;
    logic             cap_stb;
    logic             ovf_stb;
    logic [CNT_W-1:0] cap_w;
    logic [CNT_W-1:0] cap_p;

    tmr_plaus #(.CNT_W(CNT_W)) i_plaus (
        .width_i  (st_q.reg_w),
        .period_i (st_q.reg_p),
        .code_o   (chk_code)
    );

    assign cap_active = st_q.running && st_q.mode == MODE_CAP;

    tmr_capture #(.CNT_W(CNT_W)) i_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (cap_active),
        .pin_i        (pin_in),
        .cap_stb_o    (cap_stb),
        .cap_width_o  (cap_w),
        .cap_period_o (cap_p),
        .ovf_stb_o    (ovf_stb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (!st_q.running) begin
            st_d.mode = cfg_cap ? MODE_CAP : MODE_PWM;
        end

        if (st_q.mode == MODE_PWM) begin
            if (wr_width) begin
                st_d.reg_w = wr_data;
            end
            if (wr_period) begin
                st_d.reg_p = wr_data;
            end
        end

        if (!enable) begin
            st_d.running = 1'b0;
            st_d.cnt     = '0;
        end else if (!st_q.running) begin
            st_d.err  = 1'b0;
            st_d.code = ERR_NONE;
            if (cfg_cap) begin
                st_d.running = 1'b1;
                st_d.mode    = MODE_CAP;
                st_d.cnt     = '0;
            end else if (chk_code != ERR_NONE) begin
                st_d.err  = 1'b1;
                st_d.code = chk_code;
            end else begin
                st_d.running = 1'b1;
                st_d.mode    = MODE_PWM;
                st_d.act_w   = st_q.reg_w;
                st_d.act_p   = st_q.reg_p;
                st_d.cnt     = '0;
            end
        end else if (st_q.mode == MODE_PWM) begin
            if (st_q.cnt == st_q.act_p - CNT_ONE) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
                if (chk_code == ERR_NONE) begin
                    st_d.act_w = st_q.reg_w;
                    st_d.act_p = st_q.reg_p;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end else begin
            if (cap_stb) begin
                st_d.reg_w = cap_w;
                st_d.reg_p = cap_p;
                st_d.irq   = 1'b1;
            end
            if (ovf_stb) begin
                st_d.err  = 1'b1;
                st_d.code = ERR_OVF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out   = st_q.running && st_q.mode == MODE_PWM && st_q.cnt < st_q.act_w;
    assign irq       = st_q.irq;
    assign err_flag  = st_q.err;
    assign err_code  = st_q.code;
    assign rd_width  = st_q.reg_w;
    assign rd_period = st_q.reg_p;

    AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pin_out) // R11
        else $error("AST_OUT_OFF");

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq) // R3
        else $error("AST_IRQ_PULSE");

    AST_ACTIVE_PLAUSIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && st_q.mode == MODE_PWM) |->
            (st_q.act_p >= CNT_W'(2) && st_q.act_w != '0 && st_q.act_w < st_q.act_p)) // R7
        else $error("AST_ACTIVE_PLAUSIBLE");

    AST_CAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> (rd_width == $past(cap_w) && rd_period == $past(cap_p))) // R8
        else $error("AST_CAP_PAIR");

    AST_CAP_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_active && !cap_stb) |=> ($stable(rd_width) && $stable(rd_period))) // R9
        else $error("AST_CAP_READONLY");

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_stb |=> (err_flag && err_code == 2'd3)) // R10
        else $error("AST_OVF_FLAG");

endmodule

// File: tb/test_pwm_cap_timer.sv
module test_pwm_cap_timer;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_cap = 1'b0;
    logic             enable = 1'b0;
    logic             wr_width = 1'b0;
    logic             wr_period = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_width;
    logic [CNT_W-1:0] rd_period;
    logic             pin_in = 1'b0;
    logic             pin_out;
    logic             irq;
    logic             err_flag;
    logic [1:0]       err_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_cap_timer #(.CNT_W(CNT_W)) i_pwm_cap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_cap   (cfg_cap),
        .enable    (enable),
        .wr_width  (wr_width),
        .wr_period (wr_period),
        .wr_data   (wr_data),
        .rd_width  (rd_width),
        .rd_period (rd_period),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .irq       (irq),
        .err_flag  (err_flag),
        .err_code  (err_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input bit is_period, input int val);
        wr_width  = !is_period;
        wr_period = is_period;
        wr_data   = CNT_W'(val);
        @(negedge clk);
        wr_width  = 1'b0;
        wr_period = 1'b0;
    endtask

    task automatic err_case(input int w, input int p, input int code);
        do_write(1'b0, w);
        do_write(1'b1, p);
        enable = 1'b1;
        @(negedge clk);
        chk("R4/R5 err_flag", int'(err_flag), 1);
        chk("R4/R5 err_code", int'(err_code), code);
        chk("R4/R5 pin_out idle", int'(pin_out), 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pin_out", int'(pin_out), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 err_code", int'(err_code), 0);
        chk("R1 rd_width", int'(rd_width), 0);
        chk("R1 rd_period", int'(rd_period), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3, R11: sweep of all legal pairs
        for (int p = 2; p <= 6; p++) begin
            for (int w = 1; w < p; w++) begin
                do_write(1'b0, w);
                do_write(1'b1, p);
                enable = 1'b1;
                @(negedge clk);
                for (int i = 0; i < 2 * p; i++) begin
                    chk("R2 pin_out", int'(pin_out), int'((i % p) < w));
                    chk("R3 irq", int'(irq), int'(i > 0 && (i % p) == 0));
                    @(negedge clk);
                end
                enable = 1'b0;
                @(negedge clk);
                chk("R11 pin_out after disable", int'(pin_out), 0);
            end
        end

        // R4, R5: start-time check and its priority
        err_case(1, 0, 1);
        err_case(1, 1, 1);
        err_case(0, 1, 1);
        err_case(0, 5, 2);
        err_case(5, 5, 2);
        err_case(6, 5, 2);
        do_write(1'b0, 2);
        do_write(1'b1, 5);
        enable = 1'b1;
        @(negedge clk);
        chk("R4 err cleared", int'(err_flag), 0);
        chk("R4 code cleared", int'(err_code), 0);
        chk("R2 running", int'(pin_out), 1);
        enable = 1'b0;
        @(negedge clk);

        // R6: a new pair written mid-period takes effect at the boundary
        do_write(1'b0, 1);
        do_write(1'b1, 4);
        enable = 1'b1;
        @(negedge clk);
        chk("R6 idx0", int'(pin_out), 1);
        @(negedge clk);
        chk("R6 idx1", int'(pin_out), 0);
        do_write(1'b0, 3);
        chk("R6 readback width", int'(rd_width), 3);
        chk("R6 idx2 old pair", int'(pin_out), 0);
        do_write(1'b1, 6);
        chk("R6 readback period", int'(rd_period), 6);
        chk("R6 idx3 old pair", int'(pin_out), 0);
        @(negedge clk);
        for (int j = 0; j <= 6; j++) begin
            chk("R6 new pin_out", int'(pin_out), int'(j < 3 || j == 6));
            chk("R6 new irq", int'(irq), int'(j == 0 || j == 6));
            @(negedge clk);
        end
        enable = 1'b0;
        @(negedge clk);

        // R7: an implausible pair at the boundary is not loaded
        do_write(1'b0, 2);
        do_write(1'b1, 4);
        enable = 1'b1;
        @(negedge clk);
        chk("R7 idx0", int'(pin_out), 1);
        @(negedge clk);
        do_write(1'b1, 1);
        chk("R7 readback", int'(rd_period), 1);
        for (int i = 2; i < 12; i++) begin
            chk("R7 pin_out kept", int'(pin_out), int'((i % 4) < 2));
            chk("R7 irq kept", int'(irq), int'((i % 4) == 0));
            @(negedge clk);
        end
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R4 restart refused", int'(err_code), 1);
        enable = 1'b0;
        @(negedge clk);

        // R8, R3: capture sweep
        cfg_cap = 1'b1;
        @(negedge clk);
        for (int h = 1; h <= 4; h++) begin
            for (int l = 1; l <= 4; l++) begin
                pin_in = 1'b0;
                enable = 1'b1;
                repeat (2) @(negedge clk);
                pin_in = 1'b1;
                repeat (h) @(negedge clk);
                pin_in = 1'b0;
                repeat (l) @(negedge clk);
                chk("R3 no irq before close", int'(irq), 0);
                pin_in = 1'b1;
                @(negedge clk);
                chk("R3 capture irq", int'(irq), 1);
                chk("R8 width", int'(rd_width), h);
                chk("R8 period", int'(rd_period), h + l);
                chk("R8 pin_out quiet", int'(pin_out), 0);
                enable = 1'b0;
                pin_in = 1'b0;
                @(negedge clk);
            end
        end

        // R9: writes discarded in capture mode
        enable = 1'b1;
        repeat (2) @(negedge clk);
        pin_in = 1'b1;
        repeat (2) @(negedge clk);
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        pin_in = 1'b1;
        @(negedge clk);
        do_write(1'b0, 77);
        do_write(1'b1, 88);
        chk("R9 width kept", int'(rd_width), 2);
        chk("R9 period kept", int'(rd_period), 5);
        enable = 1'b0;
        pin_in = 1'b0;
        @(negedge clk);

        // R10: period never closes
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 no error yet", int'(err_flag), 0);
        pin_in = 1'b1;
        repeat (260) @(negedge clk);
        chk("R10 err_flag", int'(err_flag), 1);
        chk("R10 err_code", int'(err_code), 3);
        enable = 1'b0;
        pin_in = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule